// File: doc/BRIEF.md
# Chained Event Latch with Missed-Event Detection

This block keeps a pending flag for each of 32 chained events. Transfer engines, and an early-completion path, return completion codes. Each return port carries a 6-bit code and two chaining qualifiers: one for intermediate chaining and one for final chaining. When at least one qualifier is set, the code selects the event bit to mark pending. No enable mask gates this set path. A pending bit stays set until the downstream prioritizer acknowledges the event as serviced.

Some events are lost. This happens when a code lands on a bit that is already pending, or when two ports name the same event in one cycle. Each lost event leaves a sticky flag in a separate missed-event vector, and software clears those flags by writing ones. When a set and a clear reach the same bit in the same cycle, the set always wins. The block also presents the lowest-numbered pending event and its index, which gives the prioritizer a simple fixed-priority request.

Top module: `chain_evt_latch`

## Requirements
- R1: After a synchronous reset, the pending and missed vectors are all zero and the request valid is low.
- R2: A return port with valid high and either chaining qualifier high (intermediate, final or both) sets the pending bit whose index equals the 6-bit code. The bit shows at the output one clock later.
- R3: A return with valid low, or with valid high but both chaining qualifiers low, changes neither the pending vector nor the missed vector.
- R4: A qualified code with a value from 32 to 63 sets no pending bit and no missed bit.
- R5: A high service-acknowledge bit clears that pending bit on the next clock. Every other pending bit is left unchanged.
- R6: A qualified code that targets a bit that is already pending leaves the bit pending and sets the missed bit with the same index.
- R7: When a qualified set and an acknowledge hit the same bit in one cycle, the bit stays pending. The missed bit is set only if the bit was pending before that cycle.
- R8: When two ports deliver qualified codes with the same index in one cycle, the bit becomes pending and its missed bit is set.
- R9: Missed bits are sticky. A missed bit clears only when the matching bit of the missed-clear input is 1. A new loss in the same cycle overrides the clear.
- R10: The request valid equals the OR of the pending bits. The request index is the lowest pending index. Both follow the pending vector within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_vld_i | input | NUM_PORTS | Completion return valid, one bit per port |
| cc_mid_i | input | NUM_PORTS | Intermediate-chaining qualifier, one bit per port |
| cc_fin_i | input | NUM_PORTS | Final-chaining qualifier, one bit per port |
| cc_code_i | input | NUM_PORTS*CODE_W | Completion codes; port p occupies bits p*CODE_W upward |
| svc_ack_i | input | NUM_EVT | Service acknowledge from the prioritizer, one bit per event |
| miss_clr_i | input | NUM_EVT | Software write-one-to-clear for the missed flags |
| pend_o | output | NUM_EVT | Pending chained events |
| miss_o | output | NUM_EVT | Sticky missed-event flags |
| req_vld_o | output | 1 | At least one event is pending |
| req_idx_o | output | $clog2(NUM_EVT) | Lowest pending event index |

## Verification
The assertions treat every input as a clean synchronous level that is sampled only at the rising edge. They also treat reset as the only event that can touch the state outside the set, acknowledge and clear paths. The checks on state movement look back one cycle, so a guard flag holds them off for the first cycle after reset. The bench changes all inputs on the falling edge. It holds the return ports and acknowledges idle whenever reset is high, so no request is in flight when reset is released.

// File: rtl/chain_evt_pkg.sv
package chain_evt_pkg;
  localparam int DEF_NUM_EVT   = 32;
  localparam int DEF_CODE_W    = 6;
  localparam int DEF_NUM_PORTS = 2;

  // A code takes part only when the return is valid and at least one
  // chaining qualifier is raised.
  function automatic logic cc_qualified(input logic vld, input logic mid, input logic fin);
    return vld & (mid | fin);
  endfunction
endpackage

// File: rtl/chain_cc_decode.sv
module chain_cc_decode
  import chain_evt_pkg::*;
#(
  parameter int NUM_EVT = DEF_NUM_EVT,
  parameter int CODE_W  = DEF_CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld_i,
  input  logic               mid_i,
  input  logic               fin_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic [NUM_EVT-1:0] hit_o
);
  logic qual;
  assign qual = cc_qualified(vld_i, mid_i, fin_i);

  // Each event bit compares against the code. Codes past the top index
  // match no bit at all.
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    assign hit_o[i] = qual && (code_i == CODE_W'(i));
  end

  // R2/R3/R4: at most one bit per port, and none without a qualified code
  always_ff @(posedge clk) begin
    if (!rst) begin
      a_r2_hit_onehot: assert ($onehot0(hit_o));
      a_r3_hit_needs_qual: assert ((hit_o == '0) || (vld_i && (mid_i || fin_i)));
      a_r4_high_code_no_hit: assert ((code_i < CODE_W'(NUM_EVT)) || (hit_o == '0));
    end
  end
endmodule

// File: rtl/chain_pend_reg.sv
module chain_pend_reg #(
  parameter int NUM_EVT   = 32,
  parameter int NUM_PORTS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PORTS*NUM_EVT-1:0] hit_i,
  input  logic [NUM_EVT-1:0]           ack_i,
  output logic [NUM_EVT-1:0]           pend_o,
  output logic [NUM_EVT-1:0]           lost_o
);
  logic [NUM_EVT-1:0] set_any;
  logic [NUM_EVT-1:0] dup;
  logic [NUM_EVT-1:0] pend_q;

  // Fold the ports together and note every bit that two ports name.
  always_comb begin
    set_any = '0;
    dup     = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      dup     = dup | (set_any & hit_i[p*NUM_EVT +: NUM_EVT]);
      set_any = set_any | hit_i[p*NUM_EVT +: NUM_EVT];
    end
  end

  // An event is lost when it lands on a pending bit, or when it collides with another port.
  assign lost_o = (set_any & pend_q) | dup;

  // The set term is ORed in after the clear, so a set overrides a clear.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~ack_i) | set_any;
  end

  assign pend_o = pend_q;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2/R7: a bit that was set is pending next cycle, even with an acknowledge
  a_r7_set_beats_ack: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(set_any) & ~pend_q) == '0));
  // R5: a bit drops only when it was acknowledged
  a_r5_drop_needs_ack: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(pend_q) & ~$past(ack_i) & ~pend_q) == '0));
  // R3: a bit rises only when something set it
  a_r3_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((pend_q & ~$past(pend_q) & ~$past(hit_i[NUM_EVT-1:0])
                  & ~$past(set_any)) == '0));
endmodule

// File: rtl/chain_miss_reg.sv
module chain_miss_reg #(
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] lost_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] miss_o
);
  logic [NUM_EVT-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (rst) miss_q <= '0;
    else     miss_q <= (miss_q & ~clr_i) | lost_i;
  end

  assign miss_o = miss_q;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R9: flags are sticky unless cleared, and a fresh loss overrides a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(miss_q) & ~$past(clr_i) & ~miss_q) == '0));
  a_r9_loss_wins: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(lost_i) & ~miss_q) == '0));
  // R6: a flag rises only from a recorded loss
  a_r6_rise_needs_loss: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((miss_q & ~$past(miss_q) & ~$past(lost_i)) == '0));
endmodule

// File: rtl/chain_low_pick.sv
module chain_low_pick #(
  parameter int NUM_EVT = 32,
  localparam int IDX_W  = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] pend_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o
);
  // Scan from the top down so that the lowest pending index is written last.
  always_comb begin
    idx_o = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign vld_o = |pend_i;

  logic [NUM_EVT-1:0] below_mask;
  assign below_mask = (NUM_EVT'(1) << idx_o) - NUM_EVT'(1);

  // R10: the chosen index is pending and no lower index is pending
  always_ff @(posedge clk) begin
    if (!rst) begin
      a_r10_pick_pending: assert (!vld_o || pend_i[idx_o]);
      a_r10_pick_lowest: assert ((pend_i & below_mask) == '0);
      a_r10_vld_zero: assert (vld_o || (pend_i == '0));
    end
  end
endmodule

// File: rtl/chain_evt_latch.sv
module chain_evt_latch
  import chain_evt_pkg::*;
#(
  parameter int NUM_EVT   = DEF_NUM_EVT,
  parameter int CODE_W    = DEF_CODE_W,
  parameter int NUM_PORTS = DEF_NUM_PORTS,
  localparam int IDX_W    = $clog2(NUM_EVT)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        cc_vld_i,
  input  logic [NUM_PORTS-1:0]        cc_mid_i,
  input  logic [NUM_PORTS-1:0]        cc_fin_i,
  input  logic [NUM_PORTS*CODE_W-1:0] cc_code_i,
  input  logic [NUM_EVT-1:0]          svc_ack_i,
  input  logic [NUM_EVT-1:0]          miss_clr_i,
  output logic [NUM_EVT-1:0]          pend_o,
  output logic [NUM_EVT-1:0]          miss_o,
  output logic                        req_vld_o,
  output logic [IDX_W-1:0]            req_idx_o
);
  logic [NUM_PORTS*NUM_EVT-1:0] hits;
  logic [NUM_EVT-1:0]           lost;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    chain_cc_decode #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_dec (
      .clk    (clk),
      .rst    (rst),
      .vld_i  (cc_vld_i[p]),
      .mid_i  (cc_mid_i[p]),
      .fin_i  (cc_fin_i[p]),
      .code_i (cc_code_i[p*CODE_W +: CODE_W]),
      .hit_o  (hits[p*NUM_EVT +: NUM_EVT])
    );
  end

  chain_pend_reg #(.NUM_EVT(NUM_EVT), .NUM_PORTS(NUM_PORTS)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .hit_i  (hits),
    .ack_i  (svc_ack_i),
    .pend_o (pend_o),
    .lost_o (lost)
  );

  chain_miss_reg #(.NUM_EVT(NUM_EVT)) u_miss (
    .clk    (clk),
    .rst    (rst),
    .lost_i (lost),
    .clr_i  (miss_clr_i),
    .miss_o (miss_o)
  );

  chain_low_pick #(.NUM_EVT(NUM_EVT)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_o),
    .vld_o  (req_vld_o),
    .idx_o  (req_idx_o)
  );

  // R1: the first cycle after reset shows an empty state
  a_r1_reset_empty: assert property (@(posedge clk)
    $fell(rst) |-> (pend_o == '0 && miss_o == '0 && !req_vld_o));
endmodule

// File: tb/tb_chain_evt_latch.sv
module tb_chain_evt_latch;
  localparam int NE = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cc_vld = '0, cc_mid = '0, cc_fin = '0;
  logic [11:0] cc_code = '0;
  logic [31:0] ack = '0, clr = '0;
  logic [31:0] pend, miss;
  logic        req_vld;
  logic [4:0]  req_idx;

  always #2 clk = ~clk;  // 250 MHz

  chain_evt_latch dut (
    .clk(clk), .rst(rst), .cc_vld_i(cc_vld), .cc_mid_i(cc_mid), .cc_fin_i(cc_fin),
    .cc_code_i(cc_code), .svc_ack_i(ack), .miss_clr_i(clr),
    .pend_o(pend), .miss_o(miss), .req_vld_o(req_vld), .req_idx_o(req_idx)
  );

  int checks = 0;
  int errors = 0;

  // Port field: {valid, intermediate qualifier, final qualifier, code[5:0]}
  typedef struct packed {
    logic [8:0]  p0;
    logic [8:0]  p1;
    logic [31:0] ack;
    logic [31:0] clr;
    logic [31:0] ep;
    logic [31:0] em;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{9'b110_000011, 9'd0,           32'h0,        32'h0,        32'h0000_0008, 32'h0,         8'd2},  // R2 mid code 3
    '{9'b101_000101, 9'b111_011111,  32'h0,        32'h0,        32'h8000_0028, 32'h0,         8'd2},  // R2 fin 5, both 31
    '{9'b100_000111, 9'b010_001001,  32'h0,        32'h0,        32'h8000_0028, 32'h0,         8'd3},  // R3 unqualified
    '{9'b110_101000, 9'b101_111111,  32'h0,        32'h0,        32'h8000_0028, 32'h0,         8'd4},  // R4 codes 40, 63
    '{9'd0,          9'd0,           32'h20,       32'h0,        32'h8000_0008, 32'h0,         8'd5},  // R5 ack 5
    '{9'b110_000011, 9'd0,           32'h0,        32'h0,        32'h8000_0008, 32'h8,         8'd6},  // R6 re-hit 3
    '{9'b101_001010, 9'd0,           32'h400,      32'h0,        32'h8000_0408, 32'h8,         8'd7},  // R7 set+ack clear bit
    '{9'b110_011111, 9'd0,           32'h8000_0000,32'h0,        32'h8000_0408, 32'h8000_0008, 8'd7},  // R7 set+ack pending bit
    '{9'b110_001100, 9'b101_001100,  32'h0,        32'h0,        32'h8000_1408, 32'h8000_1008, 8'd8},  // R8 collision 12
    '{9'd0,          9'd0,           32'h0,        32'h0,        32'h8000_1408, 32'h8000_1008, 8'd9},  // R9 sticky
    '{9'd0,          9'd0,           32'h0,        32'h8,        32'h8000_1408, 32'h8000_1000, 8'd9},  // R9 clear 3
    '{9'b110_001100, 9'd0,           32'h0,        32'h1000,     32'h8000_1408, 32'h8000_1000, 8'd9},  // R9 loss beats clear
    '{9'd0,          9'd0,           32'hFFFF_FFFF,32'h0,        32'h0,         32'h8000_1000, 8'd5},  // R5 ack all
    '{9'd0,          9'd0,           32'h0,        32'hFFFF_FFFF,32'h0,         32'h0,         8'd9}   // R9 clear all
  };

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // R10: expected request derived from the expected pending vector
  task automatic chk_req(input logic [31:0] ep);
    int li;
    li = 0;
    for (int i = NE - 1; i >= 0; i--) if (ep[i]) li = i;
    chk("R10", "req_vld", {31'd0, req_vld}, {31'd0, |ep});
    if (|ep) chk("R10", "req_idx", {27'd0, req_idx}, li);
  endtask

  task automatic drive(input logic [8:0] a, input logic [8:0] b, input logic [31:0] k, input logic [31:0] c);
    {cc_vld[0], cc_mid[0], cc_fin[0], cc_code[5:0]}  = a;
    {cc_vld[1], cc_mid[1], cc_fin[1], cc_code[11:6]} = b;
    ack = k;
    clr = c;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pend after reset", pend, 32'h0);
    chk("R1", "miss after reset", miss, 32'h0);
    chk("R1", "req_vld after reset", {31'd0, req_vld}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      drive(TBL[v].p0, TBL[v].p1, TBL[v].ack, TBL[v].clr);
      @(negedge clk);
      drive('0, '0, '0, '0);
      chk($sformatf("R%0d", TBL[v].req), $sformatf("pend step %0d", v), pend, TBL[v].ep);
      chk($sformatf("R%0d", TBL[v].req), $sformatf("miss step %0d", v), miss, TBL[v].em);
      chk_req(TBL[v].ep);
    end

    // R10: acknowledging the lowest bit moves the request to the next one
    drive(9'b110_000010, 9'b101_010001, '0, '0);
    @(negedge clk);
    drive('0, '0, '0, '0);
    chk("R10", "idx low", {27'd0, req_idx}, 32'd2);
    ack = 32'h4;
    @(negedge clk);
    ack = '0;
    chk("R10", "idx next", {27'd0, req_idx}, 32'd17);

    // R1: reset in mid-run empties both vectors
    drive(9'b110_000001, 9'b110_000001, '0, '0);
    @(negedge clk);
    drive('0, '0, '0, '0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "pend after mid reset", pend, 32'h0);
    chk("R1", "miss after mid reset", miss, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule